// File: doc/BRIEF.md
# Lane Loopback and Mux Routing Controller

This block makes the digital path decisions for a set of redriver lanes. Each lane has two channels, A and B, and each channel has one receiver and one transmitter. The block takes a per-lane loopback bit, per-channel input-off and output-off bits, per-channel signal detect, an active-high power enable and a slumber enable. For every transmitter it chooses a data source and a drive state. The source is the transmitter's own receiver, the A receiver of its lane, or nothing. The drive state is active, squelched to common mode, or high impedance.

The loopback bit is active low. When it is cleared, the A receiver of the lane feeds both transmitters. Combining loopback with the input-off and output-off bits produces the mux and demux arrangements. Each channel also has an idle timer. When slumber is enabled and a receiver stays idle long enough, the timer places that channel in a low-power slumber state.

All results are registered. Each result reflects the inputs sampled at the previous rising clock edge.

Top module: `lane_route_ctrl`

## Requirements
- R1: With the lane's loopback bit `lb_n` at 1 and no off bits set, A transmit reports code 10 (active from its own receiver) and B transmit reports code 10. Mode codes are 2 bits per lane, and lane i occupies bits [2i+1:2i].
- R2: With `lb_n` at 0, A transmit reports 10 and B transmit reports 11. Code 11 means active from the lane's A receiver. Code 11 never appears on an A transmitter.
- R3: With `lb_n` at 0, output-off A set and input-off B set, A transmit reports 00 (high impedance) and B transmit reports 11.
- R4: Any transmitter whose output-off bit is set reports 00, in any loopback setting. With `lb_n` at 1 and both input-off A and output-off A set, the lane reports A=00 and B=10.
- R5: While `pwr_on` is 0, every transmitter reports 00 and every slumber output is 0, whatever the other inputs are.
- R6: A transmitter whose selected source receiver has signal detect 0 reports 01 (squelch). In loopback, B follows the A receiver's detect and ignores its own.
- R7: A transmitter whose selected source receiver has its input-off bit set reports 01.
- R8: Every output is registered and reflects the inputs at the previous rising edge. During reset all mode codes and slumber outputs are 0.
- R9: With `slumber_en` at 1, a channel's slumber output rises at the `idle_limit`-th consecutive edge at which that channel is idle (signal detect 0 or input-off 1). It does not rise earlier, and it never rises while `slumber_en` is 0.
- R10: A slumber output falls at the first edge at which its channel is no longer idle or `slumber_en` is 0.
- R11: Lanes are independent. Each lane's codes depend only on that lane's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | 1 = operate, 0 = everything high impedance |
| slumber_en | input | 1 | Enables idle-driven slumber |
| idle_limit | input | CNT_W | Consecutive idle cycles needed before slumber |
| lb_n | input | LANES | Per lane: 1 = normal, 0 = loopback/broadcast |
| in_off_a | input | LANES | A receiver off |
| in_off_b | input | LANES | B receiver off |
| out_off_a | input | LANES | A transmitter off (high impedance) |
| out_off_b | input | LANES | B transmitter off (high impedance) |
| sig_a | input | LANES | A receiver signal detect |
| sig_b | input | LANES | B receiver signal detect |
| tx_mode_a | output | 2*LANES | A transmitter mode codes |
| tx_mode_b | output | 2*LANES | B transmitter mode codes |
| slumber_a | output | LANES | A channel in slumber |
| slumber_b | output | LANES | B channel in slumber |

## Verification
Each mode code is due one rising edge after its inputs change. The bench therefore drives inputs on a falling edge and samples them on the next falling edge, which places exactly one register stage between stimulus and check.

The slumber output is due on the `idle_limit`-th idle edge. The bench counts edges and checks the output both one edge before that point (expecting 0) and at that point (expecting 1).

Exit from slumber and the power-down override are each checked one edge after the triggering input changes.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    typedef enum logic [1:0] {
        MODE_HIZ  = 2'b00,
        MODE_SQL  = 2'b01,
        MODE_OWN  = 2'b10,
        MODE_PART = 2'b11
    } tx_mode_e;
endpackage

// File: rtl/lrc_lane_map.sv
module lrc_lane_map
    import lrc_pkg::*;
(
    input  logic       pwr_on,
    input  logic       loop_n,
    input  logic       in_off_a,
    input  logic       in_off_b,
    input  logic       out_off_a,
    input  logic       out_off_b,
    input  logic       sig_a,
    input  logic       sig_b,
    output logic [1:0] mode_a,
    output logic [1:0] mode_b
);
    logic live_a;
    logic live_b;

    always_comb begin
        live_a = sig_a && !in_off_a;
        live_b = sig_b && !in_off_b;

        if (!pwr_on || out_off_a) begin
            mode_a = MODE_HIZ;
        end else if (!live_a) begin
            mode_a = MODE_SQL;
        end else begin
            mode_a = MODE_OWN;
        end

        if (!pwr_on || out_off_b) begin
            mode_b = MODE_HIZ;
        end else if (loop_n) begin
            mode_b = live_b ? MODE_OWN : MODE_SQL;
        end else begin
            mode_b = live_a ? MODE_PART : MODE_SQL;
        end
    end
endmodule

// File: rtl/lrc_idle_timer.sv
module lrc_idle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             enable,
    input  logic             idle,
    input  logic [CNT_W-1:0] limit,
    output logic             slumber
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             slm;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!pwr_on || !enable || !idle) begin
            tmr_d.cnt = '0;
            tmr_d.slm = 1'b0;
        end else begin
            tmr_d.cnt = (tmr_q.cnt == CNT_MAX) ? CNT_MAX : tmr_q.cnt + 1'b1;
            tmr_d.slm = (tmr_d.cnt >= limit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign slumber = tmr_q.slm;

    p_exit_on_activity_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> !slumber);
    p_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !slumber);
    p_pd_no_slumber_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !slumber);
endmodule

// File: rtl/lane_route_ctrl.sv
module lane_route_ctrl
    import lrc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_on,
    input  logic               slumber_en,
    input  logic [CNT_W-1:0]   idle_limit,
    input  logic [LANES-1:0]   lb_n,
    input  logic [LANES-1:0]   in_off_a,
    input  logic [LANES-1:0]   in_off_b,
    input  logic [LANES-1:0]   out_off_a,
    input  logic [LANES-1:0]   out_off_b,
    input  logic [LANES-1:0]   sig_a,
    input  logic [LANES-1:0]   sig_b,
    output logic [2*LANES-1:0] tx_mode_a,
    output logic [2*LANES-1:0] tx_mode_b,
    output logic [LANES-1:0]   slumber_a,
    output logic [LANES-1:0]   slumber_b
);
    localparam int MW = 2 * LANES;

    typedef struct packed {
        logic [MW-1:0] a;
        logic [MW-1:0] b;
    } modes_t;

    modes_t modes_d, modes_q;
    logic [MW-1:0] map_a;
    logic [MW-1:0] map_b;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lrc_lane_map u_map (
            .pwr_on    (pwr_on),
            .loop_n    (lb_n[i]),
            .in_off_a  (in_off_a[i]),
            .in_off_b  (in_off_b[i]),
            .out_off_a (out_off_a[i]),
            .out_off_b (out_off_b[i]),
            .sig_a     (sig_a[i]),
            .sig_b     (sig_b[i]),
            .mode_a    (map_a[2*i+:2]),
            .mode_b    (map_b[2*i+:2])
        );

        lrc_idle_timer #(.CNT_W(CNT_W)) u_tmr_a (
            .clk     (clk),
            .rst_n   (rst_n),
            .pwr_on  (pwr_on),
            .enable  (slumber_en),
            .idle    (!sig_a[i] || in_off_a[i]),
            .limit   (idle_limit),
            .slumber (slumber_a[i])
        );

        lrc_idle_timer #(.CNT_W(CNT_W)) u_tmr_b (
            .clk     (clk),
            .rst_n   (rst_n),
            .pwr_on  (pwr_on),
            .enable  (slumber_en),
            .idle    (!sig_b[i] || in_off_b[i]),
            .limit   (idle_limit),
            .slumber (slumber_b[i])
        );

        p_outoff_a_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_off_a[i] |=> tx_mode_a[2*i+:2] == MODE_HIZ);
        p_outoff_b_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_off_b[i] |=> tx_mode_b[2*i+:2] == MODE_HIZ);
        p_a_never_partner_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tx_mode_a[2*i+:2] != MODE_PART);
        p_partner_needs_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tx_mode_b[2*i+:2] == MODE_PART |-> $past(!lb_n[i]));
        p_dead_source_squelch_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_on && !out_off_a[i] && !sig_a[i]) |=> tx_mode_a[2*i+:2] == MODE_SQL);
    end

    always_comb begin
        modes_d   = modes_q;
        modes_d.a = map_a;
        modes_d.b = map_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            modes_q <= '0;
        end else begin
            modes_q <= modes_d;
        end
    end

    assign tx_mode_a = modes_q.a;
    assign tx_mode_b = modes_q.b;

    p_pd_all_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (tx_mode_a == '0 && tx_mode_b == '0));
endmodule

// File: tb/test_lane_route_ctrl.sv
module test_lane_route_ctrl;
    localparam int LANES = 4;
    localparam int CNT_W = 8;
    localparam int NV    = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pwr_on = 1'b1;
    logic               slumber_en = 1'b0;
    logic [CNT_W-1:0]   idle_limit = 8'd3;
    logic [LANES-1:0]   lb_n = '1;
    logic [LANES-1:0]   in_off_a = '0, in_off_b = '0;
    logic [LANES-1:0]   out_off_a = '0, out_off_b = '0;
    logic [LANES-1:0]   sig_a = '1, sig_b = '1;
    logic [2*LANES-1:0] tx_mode_a, tx_mode_b;
    logic [LANES-1:0]   slumber_a, slumber_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lane_route_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) i_lane_route_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .slumber_en(slumber_en),
        .idle_limit(idle_limit), .lb_n(lb_n), .in_off_a(in_off_a), .in_off_b(in_off_b),
        .out_off_a(out_off_a), .out_off_b(out_off_b), .sig_a(sig_a), .sig_b(sig_b),
        .tx_mode_a(tx_mode_a), .tx_mode_b(tx_mode_b),
        .slumber_a(slumber_a), .slumber_b(slumber_b)
    );

    // {lb_n, in_off_a, in_off_b, out_off_a, out_off_b, sig_a, sig_b, exp_a[1:0], exp_b[1:0]}
    localparam logic [10:0] VEC [NV] = '{
        11'b1_0_0_0_0_1_1_10_10, // R1 normal
        11'b0_0_0_0_0_1_1_10_11, // R2 broadcast
        11'b0_0_1_1_0_1_1_00_11, // R3 demux
        11'b1_1_0_1_0_1_1_00_10, // R4 mux
        11'b1_0_0_0_0_0_1_01_10, // R6 A idle
        11'b0_0_0_0_0_0_1_01_01, // R6 loop source idle
        11'b0_1_0_0_0_1_1_01_01, // R7 loop source off
        11'b1_0_1_0_0_1_1_10_01, // R7 B receiver off
        11'b1_0_0_1_1_1_1_00_00, // R4 both outputs off
        11'b0_0_0_0_1_1_0_10_00  // R4 B off in loopback
    };

    function automatic string req_of(input int k);
        case (k)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3, 8, 9: return "R4";
            4, 5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8 reset state
        repeat (3) @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            chk("R8", "reset mode a", tx_mode_a[2*i+:2], 2'b00);
            chk("R8", "reset mode b", tx_mode_b[2*i+:2], 2'b00);
            chk("R8", "reset slumber", {slumber_a[i], slumber_b[i]}, 2'b00);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table; lane i uses a rotated entry (R11 independence)
        for (int k = 0; k < NV; k++) begin
            for (int i = 0; i < LANES; i++) begin
                logic [10:0] v;
                v = VEC[(k + i) % NV];
                {lb_n[i], in_off_a[i], in_off_b[i], out_off_a[i], out_off_b[i], sig_a[i], sig_b[i]} = v[10:4];
            end
            @(negedge clk);
            for (int i = 0; i < LANES; i++) begin
                logic [10:0] v;
                v = VEC[(k + i) % NV];
                chk(req_of((k + i) % NV), "mode a", tx_mode_a[2*i+:2], v[3:2]);
                chk(req_of((k + i) % NV), "mode b", tx_mode_b[2*i+:2], v[1:0]);
            end
            chk("R11", "lane mix no slumber", {|slumber_a, |slumber_b}, 2'b00);
        end

        // R5 power-down overrides everything
        lb_n = '1; in_off_a = '0; in_off_b = '0; out_off_a = '0; out_off_b = '0;
        sig_a = '1; sig_b = '1;
        @(negedge clk);
        pwr_on = 1'b0;
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            chk("R5", "pd mode a", tx_mode_a[2*i+:2], 2'b00);
            chk("R5", "pd mode b", tx_mode_b[2*i+:2], 2'b00);
        end
        pwr_on = 1'b1;
        @(negedge clk);
        chk("R8", "resume mode a0", tx_mode_a[1:0], 2'b10);

        // R9 slumber entry after idle_limit idle edges
        slumber_en = 1'b1;
        idle_limit = 8'd5;
        sig_a[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", "slumber early", {1'b0, slumber_a[0]}, 2'b00);
        @(negedge clk);
        chk("R9", "slumber due", {1'b0, slumber_a[0]}, 2'b01);
        chk("R11", "other channels awake", {|slumber_a[3:1], |slumber_b}, 2'b00);
        chk("R6", "idle output squelched", tx_mode_a[1:0], 2'b01);

        // R10 exit on activity
        sig_a[0] = 1'b1;
        @(negedge clk);
        chk("R10", "exit on signal", {1'b0, slumber_a[0]}, 2'b00);

        // R10 exit when disabled; R9 no entry while disabled
        in_off_b[2] = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9", "input off idles", {1'b0, slumber_b[2]}, 2'b01);
        slumber_en = 1'b0;
        @(negedge clk);
        chk("R10", "exit on disable", {1'b0, slumber_b[2]}, 2'b00);
        repeat (6) @(negedge clk);
        chk("R9", "no entry when disabled", {1'b0, slumber_b[2]}, 2'b00);

        // R5 power-down clears slumber
        slumber_en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9", "re-entry", {1'b0, slumber_b[2]}, 2'b01);
        pwr_on = 1'b0;
        @(negedge clk);
        chk("R5", "pd clears slumber", {1'b0, slumber_b[2]}, 2'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule